// File: doc/BRIEF.md
# QDR Burst-of-Two SRAM Model

This block is a synthesizable behavioural model of a quad-data-rate static memory. It has a read port with its own output bus and a write port with its own input bus. The two ports share one address bus: the rising edge of K samples it for a read, and the rising edge of K# samples it for a write. Every access moves one wide word as two half-width beats on consecutive clock edges. The write side takes one beat on K and one on K#. The read side returns one beat on each rising edge of the output clock pair C/C#. In single clock mode, K/K# act as the output clocks instead. Both port selects are active low and are sampled only on K.

Each write beat carries its own active-low byte-lane selects. A masked lane leaves the stored bits unchanged. A write and a read that start on the same K edge at the same address return the new data to the read, with no added delay. The model has no output-enable pin. A drive-enable output marks when the data bus would be driven, and it drops by itself once the read stream stops. The array depth is a parameter. The address bus keeps its full width, and the upper bits fold onto a smaller array. An option makes locations that were never written read as zero.

Top module: `qdr_sram`

## Requirements
- R1: While reset is asserted and after it is released, `q_en_o` is low until the first read data is presented.
- R2: In dual-clock mode, a read accepted at K rise n behaves as follows. Bits [35:0] of the stored word are driven with `q_en_o` high from the first C rise after K rise n+1 until the next C# rise. Bits [71:36] are driven from that C# rise until the next C rise.
- R3: A write accepted at a K rise (`wsel_n` low) works in two steps. That K rise captures `d_i` as stored bits [35:0]. The following K# rise captures `d_i` as bits [71:36] and `addr_i` as the write address.
- R4: `bsel_n[i]` low enables lane i, which is bits [9i+8:9i] of the beat sampled on the same edge. The K-rise beat maps to stored lanes 0..3 and the K#-rise beat maps to lanes 4..7. A lane whose select is high keeps its stored bits.
- R5: When `wsel_n` is high at a K rise, the memory ignores `d_i` and `bsel_n` at that edge and `addr_i` at the following K# rise.
- R6: Reads and writes may each start on every K rise. Back-to-back reads give an unbroken beat stream with `q_en_o` held high.
- R7: A read and a write to the same address that start on the same K rise return the newly written lanes to the read. Masked lanes keep their old value.
- R8: A write that starts on the K rise after a read of the same address is not seen by that read. A later read sees it.
- R9: Once no read data is pending, `q_en_o` falls at the next output-clock rise.
- R10: `single_clk_i` is sampled only while reset is asserted. When it was high, K/K# replace C/C#: beat [35:0] starts at K rise n+2 for a read accepted at K rise n, and beat [71:36] starts at the following K# rise.
- R11: With `INIT_ZERO` set, any lane that has not been written since reset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Input clock K; port selects, read address and low write beat |
| clk_kn | input | 1 | Input clock K#; write address and high write beat |
| clk_c | input | 1 | Output clock C (dual-clock mode) |
| clk_cn | input | 1 | Output clock C# (dual-clock mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_clk_i | input | 1 | High during reset selects single clock mode |
| rsel_n | input | 1 | Read port select, active low |
| wsel_n | input | 1 | Write port select, active low |
| addr_i | input | ADDR_W | Shared address bus |
| d_i | input | BEAT_W | Write data beat |
| bsel_n | input | LANES | Byte-lane write selects, active low |
| q_o | output | BEAT_W | Read data beat |
| q_en_o | output | 1 | Output drive enable; low means the bus floats |

## Verification
The bench builds the model with `DEPTH` = 16 and `INIT_ZERO` = 1. With this depth, full-address-bus traffic covers most of the array in a few dozen cycles. It can also keep some locations unwritten to check that they read as zero. Because unwritten lanes read as zero, the reference model starts from a known all-zero image after each reset. This lets the bench compute partial-lane and forwarded reads exactly. The bench then resets the model a second time with single clock mode selected, so both output-clock variants and their latencies are exercised.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
   localparam int unsigned QDR_BEATS = 2;

   typedef enum logic {
      CLK_DUAL   = 1'b0,
      CLK_SINGLE = 1'b1
   } qdr_clk_mode_e;
endpackage

// File: rtl/qdr_wr_port.sv
module qdr_wr_port #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned BEAT_W = 36,
   parameter int unsigned LANES  = 4
) (
   input  logic                  clk_k,
   input  logic                  rst_n,
   input  logic                  wsel_n,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [BEAT_W-1:0]     d_i,
   input  logic [LANES-1:0]      bsel_n,
   output logic                  commit_o,
   output logic [IDX_W-1:0]      cidx_o,
   output logic [2*BEAT_W-1:0]   cdata_o,
   output logic [2*LANES-1:0]    cbe_o
);
   logic                 pend_q;
   logic [BEAT_W-1:0]    lo_d_q;
   logic [LANES-1:0]     lo_be_q;

   // low beat and its lane enables are taken on K; nothing is taken when deselected
   always_ff @(posedge clk_k or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         lo_d_q  <= '0;
         lo_be_q <= '0;
      end else begin
         pend_q <= ~wsel_n;
         if (!wsel_n) begin
            lo_d_q  <= d_i;
            lo_be_q <= ~bsel_n;
         end
      end
   end

   // high beat, its lanes and the address are presented live and committed on K#
   assign commit_o = pend_q;
   assign cidx_o   = addr_i[IDX_W-1:0];
   assign cdata_o  = {d_i, lo_d_q};
   assign cbe_o    = {~bsel_n, lo_be_q};

   generate
      if (ADDR_W > IDX_W) begin : g_fold
         logic unused_hi_addr;
         assign unused_hi_addr = ^addr_i[ADDR_W-1:IDX_W];
      end
   endgenerate
endmodule

// File: rtl/qdr_rd_port.sv
module qdr_rd_port #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned IDX_W  = 8
) (
   input  logic              clk_k,
   input  logic              rst_n,
   input  logic              rsel_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [IDX_W-1:0]  ridx_o,
   output logic              vld_o
);
   logic req_q;

   always_ff @(posedge clk_k or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         vld_o  <= 1'b0;
         ridx_o <= '0;
      end else begin
         req_q <= ~rsel_n;
         vld_o <= req_q;
         if (!rsel_n) ridx_o <= addr_i[IDX_W-1:0];
      end
   end

   generate
      if (ADDR_W > IDX_W) begin : g_fold
         logic unused_hi_addr;
         assign unused_hi_addr = ^addr_i[ADDR_W-1:IDX_W];
      end
   endgenerate
endmodule

// File: rtl/qdr_store.sv
module qdr_store #(
   parameter int unsigned DEPTH     = 256,
   parameter int unsigned IDX_W     = 8,
   parameter int unsigned LANE_W    = 9,
   parameter int unsigned NLANE     = 8,
   parameter bit          INIT_ZERO = 1'b0
) (
   input  logic                      clk_k,
   input  logic                      clk_kn,
   input  logic                      rst_n,
   input  logic                      we_i,
   input  logic [IDX_W-1:0]          widx_i,
   input  logic [NLANE*LANE_W-1:0]   wdata_i,
   input  logic [NLANE-1:0]          wbe_i,
   input  logic [IDX_W-1:0]          ridx_i,
   output logic [NLANE*LANE_W-1:0]   rdata_o
);
   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] lane_q;
      logic              chk_arm;
      logic [IDX_W-1:0]  chk_idx;
      logic [LANE_W-1:0] chk_old;

      always_ff @(posedge clk_kn) begin
         if (we_i && wbe_i[g]) mem[widx_i] <= wdata_i[g*LANE_W +: LANE_W];
      end

      if (INIT_ZERO) begin : g_flag
         logic [DEPTH-1:0] written_q;
         always_ff @(posedge clk_kn or negedge rst_n) begin
            if (!rst_n) written_q <= '0;
            else if (we_i && wbe_i[g]) written_q[widx_i] <= 1'b1;
         end
         always_ff @(posedge clk_k) begin
            lane_q <= written_q[ridx_i] ? mem[ridx_i] : '0;
         end
      end else begin : g_raw
         always_ff @(posedge clk_k) begin
            lane_q <= mem[ridx_i];
         end
      end

      assign rdata_o[g*LANE_W +: LANE_W] = lane_q;

      always_ff @(posedge clk_kn or negedge rst_n) begin
         if (!rst_n) chk_arm <= 1'b0;
         else        chk_arm <= we_i && !wbe_i[g];
      end
      always_ff @(posedge clk_kn) begin
         chk_idx <= widx_i;
         chk_old <= mem[widx_i];
      end

      // R4: a masked lane keeps its stored bits across a commit
      p_lane_hold_r4: assert property (@(posedge clk_kn) disable iff (!rst_n)
         chk_arm |-> (mem[chk_idx] === chk_old));
   end
endmodule

// File: rtl/qdr_out_stage.sv
module qdr_out_stage #(
   parameter int unsigned BEAT_W = 36
) (
   input  logic                clk_p,
   input  logic                clk_n,
   input  logic                rst_n,
   input  logic                vld_i,
   input  logic [2*BEAT_W-1:0] data_i,
   output logic                en_o,
   output logic [BEAT_W-1:0]   q_o
);
   logic              tp_q, tn_q;
   logic [BEAT_W-1:0] lo_q, hi_q;

   // both halves are held from the rising edge so the falling domain never
   // samples the read pipeline
   always_ff @(posedge clk_p or negedge rst_n) begin
      if (!rst_n) begin
         tp_q <= 1'b0;
         en_o <= 1'b0;
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         tp_q <= ~tp_q;
         en_o <= vld_i;
         if (vld_i) begin
            lo_q <= data_i[BEAT_W-1:0];
            hi_q <= data_i[2*BEAT_W-1:BEAT_W];
         end
      end
   end

   always_ff @(posedge clk_n or negedge rst_n) begin
      if (!rst_n) tn_q <= 1'b0;
      else        tn_q <= tp_q;
   end

   // toggles differ between a rising edge and the next falling-clock rise
   assign q_o = (tp_q != tn_q) ? lo_q : hi_q;

   // R2: drive starts only for data presented on the previous rising edge
   p_en_from_data_r2: assert property (@(posedge clk_p) disable iff (!rst_n)
      $rose(en_o) |-> $past(vld_i));

   // R9: drive stops only after the pipeline ran empty
   p_float_when_idle_r9: assert property (@(posedge clk_p) disable iff (!rst_n)
      $fell(en_o) |-> !$past(vld_i));
endmodule

// File: rtl/qdr_sram.sv
module qdr_sram #(
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned BEAT_W    = 36,
   parameter int unsigned LANES     = 4,
   parameter int unsigned DEPTH     = 256,
   parameter bit          INIT_ZERO = 1'b0
) (
   input  logic              clk_k,
   input  logic              clk_kn,
   input  logic              clk_c,
   input  logic              clk_cn,
   input  logic              rst_n,
   input  logic              single_clk_i,
   input  logic              rsel_n,
   input  logic              wsel_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BEAT_W-1:0] d_i,
   input  logic [LANES-1:0]  bsel_n,
   output logic [BEAT_W-1:0] q_o,
   output logic              q_en_o
);
   import qdr_pkg::*;

   localparam int unsigned IDX_W  = $clog2(DEPTH);
   localparam int unsigned LANE_W = BEAT_W / LANES;
   localparam int unsigned NLANE  = LANES * QDR_BEATS;
   localparam int unsigned WORD_W = BEAT_W * QDR_BEATS;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 2");
      assert (IDX_W <= ADDR_W)
         else $error("DEPTH exceeds the address range");
      assert (LANE_W * LANES == BEAT_W)
         else $error("BEAT_W must split evenly into LANES");
   end

   qdr_clk_mode_e          mode_q;
   logic                   commit;
   logic [IDX_W-1:0]       cidx;
   logic [WORD_W-1:0]      cdata;
   logic [NLANE-1:0]       cbe;
   logic [IDX_W-1:0]       ridx;
   logic                   rvld;
   logic [WORD_W-1:0]      rdata;
   logic                   en_c, en_k;
   logic [BEAT_W-1:0]      q_c, q_k;

   // clock mode is latched only while reset is held
   always_ff @(posedge clk_k) begin
      if (!rst_n) mode_q <= qdr_clk_mode_e'(single_clk_i);
   end

   // R10: the sampled clock mode never changes outside reset
   p_mode_frozen_r10: assert property (@(posedge clk_k) disable iff (!rst_n)
      rst_n |=> $stable(mode_q));

   qdr_wr_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BEAT_W(BEAT_W), .LANES(LANES)) u_wr (
      .clk_k(clk_k), .rst_n(rst_n), .wsel_n(wsel_n), .addr_i(addr_i), .d_i(d_i),
      .bsel_n(bsel_n), .commit_o(commit), .cidx_o(cidx), .cdata_o(cdata), .cbe_o(cbe));

   qdr_rd_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rd (
      .clk_k(clk_k), .rst_n(rst_n), .rsel_n(rsel_n), .addr_i(addr_i),
      .ridx_o(ridx), .vld_o(rvld));

   qdr_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LANE_W(LANE_W), .NLANE(NLANE),
               .INIT_ZERO(INIT_ZERO)) u_store (
      .clk_k(clk_k), .clk_kn(clk_kn), .rst_n(rst_n), .we_i(commit), .widx_i(cidx),
      .wdata_i(cdata), .wbe_i(cbe), .ridx_i(ridx), .rdata_o(rdata));

   qdr_out_stage #(.BEAT_W(BEAT_W)) u_out_c (
      .clk_p(clk_c), .clk_n(clk_cn), .rst_n(rst_n), .vld_i(rvld), .data_i(rdata),
      .en_o(en_c), .q_o(q_c));

   qdr_out_stage #(.BEAT_W(BEAT_W)) u_out_k (
      .clk_p(clk_k), .clk_n(clk_kn), .rst_n(rst_n), .vld_i(rvld), .data_i(rdata),
      .en_o(en_k), .q_o(q_k));

   assign q_o    = (mode_q == CLK_SINGLE) ? q_k  : q_c;
   assign q_en_o = (mode_q == CLK_SINGLE) ? en_k : en_c;
endmodule

// File: tb/qdr_sram_tb.sv
module qdr_sram_tb;
   localparam int DEPTH = 16;

   logic        clk_k, clk_d, rst_n, single_sel;
   logic        clk_kn, clk_c, clk_cn;
   logic        rsel_n, wsel_n;
   logic [17:0] addr;
   logic [35:0] d;
   logic [3:0]  bsel_n;
   logic [35:0] q;
   logic        q_en;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   typedef struct {
      int          tgt;
      bit          en;
      logic [35:0] lo;
      logic [35:0] hi;
      string       tag;
   } item_t;
   item_t exp_q[$];
   logic [71:0] sh [DEPTH];

   qdr_sram #(.DEPTH(DEPTH), .INIT_ZERO(1'b1)) u_dut (
      .clk_k(clk_k), .clk_kn(clk_kn), .clk_c(clk_c), .clk_cn(clk_cn), .rst_n(rst_n),
      .single_clk_i(single_sel), .rsel_n(rsel_n), .wsel_n(wsel_n), .addr_i(addr),
      .d_i(d), .bsel_n(bsel_n), .q_o(q), .q_en_o(q_en));

   // 125 MHz K; C lags by 2 ns in dual mode and is tied high in single mode
   initial begin
      clk_k = 0; clk_d = 0;
      forever begin
         #2 clk_d = clk_k;
         #2 clk_k = ~clk_k;
      end
   end
   assign clk_kn = ~clk_k;
   assign clk_c  = single_sel ? 1'b1 : clk_d;
   assign clk_cn = single_sel ? 1'b1 : ~clk_d;

   task automatic check(bit ok, string tag, logic [36:0] act, logic [36:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: one popped item per K cycle, two beats sampled per item
   initial begin
      forever begin
         @(posedge clk_k);
         cyc++;
         if (exp_q.size() > 0 && exp_q[0].tgt == cyc) begin
            item_t it;
            int lo_off, hi_off;
            it = exp_q.pop_front();
            lo_off = single_sel ? 1 : 3;
            hi_off = single_sel ? 5 : 7;
            #(lo_off);
            check((q_en === it.en) && (!it.en || q === it.lo), {it.tag, " low beat"},
                  {q_en, q}, {it.en, it.lo});
            #(hi_off - lo_off);
            check((q_en === it.en) && (!it.en || q === it.hi), {it.tag, " high beat"},
                  {q_en, q}, {it.en, it.hi});
         end
      end
   end

   // driver: one call per K cycle, pushes the expected read result
   task automatic op(bit rd, int ra, bit wr, int wa, logic [71:0] wd, logic [7:0] bwn,
                     string tag);
      item_t it;
      @(posedge clk_kn); #1;
      rsel_n = ~rd; wsel_n = ~wr;
      addr = 18'(ra); d = wd[35:0]; bsel_n = bwn[3:0];
      if (wr) begin
         for (int j = 0; j < 8; j++)
            if (!bwn[j]) sh[wa % DEPTH][j*9 +: 9] = wd[j*9 +: 9];
      end
      it.tgt = cyc + 1 + (single_sel ? 2 : 1);
      it.en  = rd;
      it.lo  = sh[ra % DEPTH][35:0];
      it.hi  = sh[ra % DEPTH][71:36];
      it.tag = tag;
      exp_q.push_back(it);
      @(posedge clk_k); #1;
      addr = 18'(wa); d = wd[71:36]; bsel_n = bwn[7:4];
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) op(0, 0, 0, 0, {72{1'b1}}, 8'h00, tag);
   endtask

   task automatic do_reset(bit single);
      rst_n = 0; rsel_n = 1; wsel_n = 1; addr = '0; d = '0; bsel_n = '1;
      single_sel = single;
      for (int i = 0; i < DEPTH; i++) sh[i] = '0;
      repeat (4) @(posedge clk_k);
      #3 check(q_en === 1'b0, "R1 during reset", {q_en, q}, 37'd0);
      @(posedge clk_kn); #1 rst_n = 1;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk_k); #3;
         check(q_en === 1'b0, "R1 after reset", {q_en, q}, 37'd0);
      end
   endtask

   function automatic logic [71:0] pat(int a, int s);
      return {8'(s * 7 + a), 32'hC3A5_0000 + 32'(a * 131 + s), 32'h5A17_0F00 ^ 32'(s * 977 + a)};
   endfunction

   initial begin
      rst_n = 0; single_sel = 0;
      do_reset(0);
      // R3 then R2: full write, later read
      op(0, 0, 1, 3, pat(3, 1), 8'h00, "R3");
      idle(1, "R9");
      op(1, 3, 0, 0, '0, 8'hFF, "R2");
      idle(2, "R9");
      // R4: lanes 1,3 of low beat and 4,6 of high beat written
      op(0, 0, 1, 3, pat(3, 2), 8'hA5, "R4");
      op(1, 3, 0, 0, '0, 8'hFF, "R4");
      // R5: deselected write with enables and address presented
      op(0, 3, 0, 3, pat(9, 9), 8'h00, "R5");
      op(1, 3, 0, 0, '0, 8'hFF, "R5");
      idle(1, "R9");
      // R6: back-to-back writes, reads, and both at once
      for (int i = 0; i < 8; i++) op(0, 0, 1, i, pat(i, 3), 8'h00, "R6");
      for (int i = 0; i < 8; i++) op(1, i, 0, 0, '0, 8'hFF, "R6");
      for (int i = 0; i < 4; i++) op(1, 7 - i, 1, i + 8, pat(i + 8, 4), 8'h00, "R6");
      for (int i = 0; i < 4; i++) op(1, i + 8, 0, 0, '0, 8'hFF, "R6");
      // R7: same-edge same-address forwarding, full and partial
      op(1, 5, 1, 5, pat(5, 5), 8'h00, "R7");
      op(1, 5, 1, 5, pat(5, 6), 8'hF0, "R7");
      idle(1, "R9");
      // R8: write one cycle after read is not seen by it, later read sees it
      op(1, 6, 0, 0, '0, 8'hFF, "R8");
      op(0, 0, 1, 6, pat(6, 7), 8'h00, "R8");
      op(1, 6, 0, 0, '0, 8'hFF, "R8");
      // R11: never-written location and partially written location
      op(1, 14, 0, 0, '0, 8'hFF, "R11");
      op(0, 0, 1, 13, pat(13, 8), 8'hFE, "R11");
      op(1, 13, 0, 0, '0, 8'hFF, "R11");
      idle(4, "R9");
      wait (exp_q.size() == 0);
      repeat (2) @(posedge clk_k);

      // R10: single clock mode
      do_reset(1);
      op(0, 0, 1, 2, pat(2, 10), 8'h00, "R10");
      op(1, 2, 1, 4, pat(4, 11), 8'h0F, "R10");
      op(1, 4, 0, 0, '0, 8'hFF, "R10");
      op(1, 2, 1, 2, pat(2, 12), 8'h00, "R10");
      op(1, 9, 0, 0, '0, 8'hFF, "R10");
      idle(4, "R10");
      wait (exp_q.size() == 0);
      repeat (2) @(posedge clk_k);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_k);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule